// File: doc/BRIEF.md
# Power-of-Two Watchdog Timer

This block is a memory-mapped watchdog. Software chooses a timeout of 1 to 128 seconds as a logarithmic code, picks whether expiry raises a reset request together with an interrupt or the interrupt alone, and then arms the timer. While the timer runs, software must keep writing a clear command to restart the countdown. If no clear arrives before the countdown ends, the expiry outputs fire.

A prescaler divides the system clock into one-second ticks. Its length is a parameter, so a simulation can use a very short second. Every arm or clear is confirmed through a status flag that rises a fixed number of cycles after the command. Every disable is confirmed the same way by the flag falling. Software polls this flag before it moves on, and it changes the period only while the flag reads 0.

The register port is a plain address/data interface. A write is committed on the clock edge where the write strobe is high. Read data is combinational from the address while the read strobe is high.

Top module: `pow2_watchdog`

## Requirements
- R1: After reset the period code reads 9, the reset selection reads 0, the control word reads 0, and both expiry outputs are low.
- R2: The period code is at offset 0x3004, bits [3:0]. The reset selection is at offset 0x3008, bits [1:0]. The control word is at offset 0x300C with enable at bit 0, clear at bit 1 (which always reads 0) and the read-only status at bit 8. All other bits, and any other offset, read 0. Reads return 0 while the read strobe is low.
- R3: A period code below 3 is stored as 3, and a code above 10 is stored as 10.
- R4: The timeout is 2^(code-3) seconds, with one second equal to TICK_CYCLES clocks. The interrupt goes high at the edge exactly 2^(code-3)*TICK_CYCLES clocks after the edge that committed the arming write.
- R5: With reset selection 0, expiry also raises the reset request for exactly one cycle, at the same edge as the interrupt. With selection 1, 2 or 3, expiry raises the interrupt only.
- R6: The interrupt stays high until a clear or a disable is committed, and it drops at that edge.
- R7: A committed load (a clear while enabling, or a change of enable from 0 to 1) drives status to 0 at that edge. Status then reads 1 exactly ACK_LAT edges after the load.
- R8: A write that clears enable stops the countdown at once. Status reads 0 exactly ACK_LAT edges after that write.
- R9: A clear written with enable 0 is ignored: the counter does not start, status stays 0, and no expiry follows.
- R10: A period write while the timer runs does not change the current countdown. The new code takes effect at the next clear.
- R11: A clear committed on the same edge as the final tick reloads the full period, and that expiry does not happen.
- R12: Setting enable from 0 to 1 without the clear bit also loads a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, committed at the rising edge |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Combinational read data |
| rst_req_o | output | 1 | Single-cycle reset request on expiry |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
Two events can fall in the same cycle: a software clear and the countdown's final tick. The bench arms a one-second period and places a clear write so that it commits on the very edge where the expiry would register. It then checks that the interrupt and the reset request stay low, that status drops, and that a full period later the expiry arrives on exact cycle count. Disable writes are also checked against a pending interrupt in the same way. Outside these directed cases, random period codes and selections are checked against expiry times computed in the bench.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned CODE_LO_I = 3;
  localparam int unsigned CODE_HI_I = 10;
  // seconds counter must hold 2^(CODE_HI-CODE_LO)
  localparam int unsigned SEC_W     = CODE_HI_I - CODE_LO_I + 1;

  localparam logic [CODE_W-1:0] CODE_LO  = CODE_W'(CODE_LO_I);
  localparam logic [CODE_W-1:0] CODE_HI  = CODE_W'(CODE_HI_I);
  localparam logic [CODE_W-1:0] CODE_RST = 4'd9;

  localparam logic [15:0] OFS_PERIOD = 16'h3004;
  localparam logic [15:0] OFS_SEL    = 16'h3008;
  localparam logic [15:0] OFS_CTRL   = 16'h300C;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_CLR_BIT  = 1;
  localparam int unsigned CTRL_STAT_BIT = 8;

  localparam logic [SEL_W-1:0] SEL_BOTH = 2'd0;

  typedef struct packed {
    logic load;
    logic stop;
  } wdt_cmd_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    if (c < CODE_LO)      return CODE_LO;
    else if (c > CODE_HI) return CODE_HI;
    else                  return c;
  endfunction
endpackage

// File: rtl/wdt_regfile.sv
`timescale 1ns/1ps
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic                 status_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [CODE_W-1:0]    period_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 en_o,
  output wdt_cmd_t             cmd_o
);
  localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(OFS_PERIOD);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTRL);

  logic hit_per, hit_sel, hit_ctl;
  logic wr_en, wr_clr;
  logic [CODE_W-1:0] period_q;
  logic [SEL_W-1:0]  sel_q;
  logic              en_q;
  logic              unused_hi;

  assign hit_per   = (addr_i == A_PER);
  assign hit_sel   = (addr_i == A_SEL);
  assign hit_ctl   = (addr_i == A_CTL);
  assign wr_en     = wdata_i[CTRL_EN_BIT];
  assign wr_clr    = wdata_i[CTRL_CLR_BIT];
  assign unused_hi = ^wdata_i[DATA_W-1:CODE_W];

  // load: clear while (staying) enabled, or enable 0->1; clear with enable 0 does nothing
  always_comb begin
    cmd_o.load = we_i && hit_ctl && wr_en && (wr_clr || !en_q);
    cmd_o.stop = we_i && hit_ctl && !wr_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= CODE_RST;
      sel_q    <= '0;
      en_q     <= 1'b0;
    end else if (we_i) begin
      if (hit_per) period_q <= clamp_code(wdata_i[CODE_W-1:0]);
      if (hit_sel) sel_q    <= wdata_i[SEL_W-1:0];
      if (hit_ctl) en_q     <= wr_en;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (hit_per) rdata_o[CODE_W-1:0] = period_q;
      if (hit_sel) rdata_o[SEL_W-1:0]  = sel_q;
      if (hit_ctl) begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_STAT_BIT] = status_i;
      end
    end
  end

  assign period_o = period_q;
  assign sel_o    = sel_q;
  assign en_o     = en_q;
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int unsigned TICK_CYCLES = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  wdt_cmd_t          cmd_i,
  input  logic [CODE_W-1:0] period_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [SEC_W-1:0] secs_q, load_val;
  logic             run_q, irq_q, rreq_q;

  assign load_val = SEC_W'(1) << (period_i - CODE_LO);

  // stop beats load beats tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q <= '0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      rreq_q <= 1'b0;
      if (cmd_i.stop) begin
        run_q <= 1'b0;
        irq_q <= 1'b0;
      end else if (cmd_i.load) begin
        run_q  <= 1'b1;
        secs_q <= load_val;
        irq_q  <= 1'b0;
      end else if (run_q && tick_i) begin
        if (secs_q == SEC_W'(1)) begin
          run_q  <= 1'b0;
          secs_q <= '0;
          irq_q  <= 1'b1;
          rreq_q <= (sel_i == SEL_BOTH);
        end else begin
          secs_q <= secs_q - 1'b1;
        end
      end
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/wdt_ack_sync.sv
`timescale 1ns/1ps
module wdt_ack_sync #(
  parameter int unsigned ACK_LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  output logic status_o
);
  logic [ACK_LAT-1:0] pipe_q;

  generate
    if (ACK_LAT == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pipe_q <= '0;
        else if (load_i) pipe_q <= '0;
        else             pipe_q <= en_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pipe_q <= '0;
        else if (load_i) pipe_q <= '0;
        else             pipe_q <= {pipe_q[ACK_LAT-2:0], en_i};
      end
    end
  endgenerate

  assign status_o = pipe_q[ACK_LAT-1];
endmodule

// File: rtl/pow2_watchdog.sv
`timescale 1ns/1ps
module pow2_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TICK_CYCLES = 50_000_000,
  parameter int unsigned ACK_LAT     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic [CODE_W-1:0] period_q;
  logic [SEL_W-1:0]  sel_q;
  logic              en_q;
  logic              status_q;
  logic              tick;
  wdt_cmd_t          cmd;

  wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .re_i     (re_i),
    .status_i (status_q),
    .rdata_o  (rdata_o),
    .period_o (period_q),
    .sel_o    (sel_q),
    .en_o     (en_q),
    .cmd_o    (cmd)
  );

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cmd.load),
    .tick_o    (tick)
  );

  wdt_countdown u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cmd_i     (cmd),
    .period_i  (period_q),
    .sel_i     (sel_q),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  wdt_ack_sync #(.ACK_LAT(ACK_LAT)) u_ack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .load_i   (cmd.load),
    .status_o (status_q)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              rst_req_i,
  input logic              irq_i,
  input logic              en_i,
  input logic              load_i,
  input logic              status_i,
  input logic [CODE_W-1:0] period_i,
  input logic [SEL_W-1:0]  sel_i
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTRL);

  assert_rst_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);

  assert_rst_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> (irq_i && sel_i == SEL_BOTH));

  assert_irq_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !(we_i && addr_i == A_CTL)) |=> irq_i);

  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_i);

  assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !status_i);

  assert_period_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i >= CODE_LO && period_i <= CODE_HI));

  assert_clr_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_CTL) |-> !rdata_i[CTRL_CLR_BIT]);
endmodule

bind pow2_watchdog wdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_i   (rdata_o),
  .rst_req_i (rst_req_o),
  .irq_i     (irq_o),
  .en_i      (en_q),
  .load_i    (cmd.load),
  .status_i  (status_q),
  .period_i  (period_q),
  .sel_i     (sel_q)
);

// File: tb/pow2_watchdog_tb.sv
`timescale 1ns/1ps
module pow2_watchdog_tb;
  localparam int unsigned TICK = 8;
  localparam int unsigned LAT  = 3;
  localparam logic [15:0] A_PER = 16'h3004;
  localparam logic [15:0] A_SEL = 16'h3008;
  localparam logic [15:0] A_CTL = 16'h300C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pow2_watchdog #(.ADDR_W(16), .DATA_W(32), .TICK_CYCLES(TICK), .ACK_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq)
  );

  function automatic int clamp_b(input int c);
    if (c < 3) return 3;
    if (c > 10) return 10;
    return c;
  endfunction

  function automatic int cycles_for(input int c);
    return (1 << (clamp_b(c) - 3)) * TICK;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1;
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1;
    d = rdata;
    re = 1'b0;
  endtask

  task automatic status_is(input string req, input logic exp);
    logic [31:0] v;
    rd(A_CTL, v);
    check(req, {31'd0, v[8]}, {31'd0, exp});
  endtask

  // disabled and status 0 on entry; program, arm with ctl, watch ack and expiry
  task automatic arm_and_expect(input int code, input int sel, input logic [31:0] ctl);
    int n;
    n = cycles_for(code);
    wr(A_PER, 32'(code));
    wr(A_SEL, 32'(sel));
    wr(A_CTL, ctl);
    status_is("R7 ack low at load", 1'b0);
    step(LAT - 1);
    status_is("R7 ack before latency", 1'b0);
    step(1);
    status_is("R7 ack after latency", 1'b1);
    step(n - 1 - LAT);
    check("R4 no early expiry", {31'd0, irq}, 32'd0);
    check("R5 no early reset", {31'd0, rst_req}, 32'd0);
    step(1);
    check("R4 expiry on time", {31'd0, irq}, 32'd1);
    check("R5 reset per selection", {31'd0, rst_req}, {31'd0, (sel % 4) == 0});
    step(1);
    check("R5 reset single cycle", {31'd0, rst_req}, 32'd0);
    check("R6 irq held", {31'd0, irq}, 32'd1);
  endtask

  task automatic disarm();
    wr(A_CTL, 32'd0);
    check("R6 irq dropped by disable", {31'd0, irq}, 32'd0);
    step(LAT - 1);
    status_is("R8 ack held before latency", 1'b1);
    step(1);
    status_is("R8 ack released", 1'b0);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unsigned r;
    r = $urandom(32'h1bad5eed);

    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    rd(A_PER, v); check("R1 period reset", v, 32'd9);
    rd(A_SEL, v); check("R1 sel reset", v, 32'd0);
    rd(A_CTL, v); check("R1 ctrl reset", v, 32'd0);
    check("R1 irq low", {31'd0, irq}, 32'd0);
    check("R1 rst low", {31'd0, rst_req}, 32'd0);

    // R2 map and masking
    rd(16'h3000, v); check("R2 unmapped reads 0", v, 32'd0);
    wr(A_SEL, 32'hFFFF_FFFF);
    rd(A_SEL, v); check("R2 sel masked", v, 32'd3);
    addr = A_SEL; #1; check("R2 no read strobe gives 0", rdata, 32'd0);
    wr(A_PER, 32'hFFFF_FFF5);
    rd(A_PER, v); check("R2 period masked", v, 32'd5);

    // R3 clamping
    wr(A_PER, 32'd0);  rd(A_PER, v); check("R3 clamp low 0", v, 32'd3);
    wr(A_PER, 32'd2);  rd(A_PER, v); check("R3 clamp low 2", v, 32'd3);
    wr(A_PER, 32'd11); rd(A_PER, v); check("R3 clamp high 11", v, 32'd10);
    wr(A_PER, 32'd15); rd(A_PER, v); check("R3 clamp high 15", v, 32'd10);

    // R9 clear without enable ignored
    wr(A_PER, 32'd3);
    wr(A_CTL, 32'h2);
    rd(A_CTL, v); check("R9 ctrl after lone clear", v, 32'd0);
    step(3 * TICK);
    check("R9 no expiry", {31'd0, irq}, 32'd0);
    status_is("R9 ack stays low", 1'b0);

    // R5 every selection
    for (int s = 0; s < 4; s++) begin
      arm_and_expect(3, s, 32'h3);
      rd(A_CTL, v); check("R2 ctrl readback running", v, 32'h101);
      disarm();
    end

    // R12 enable alone starts a full period
    arm_and_expect(4, 2, 32'h1);
    disarm();

    // R6 clear drops irq, then re-expires
    arm_and_expect(3, 0, 32'h3);
    step(5);
    check("R6 irq still high", {31'd0, irq}, 32'd1);
    wr(A_CTL, 32'h3);
    check("R6 irq dropped by clear", {31'd0, irq}, 32'd0);
    step(TICK - 1);
    check("R4 reexpiry not early", {31'd0, irq}, 32'd0);
    step(1);
    check("R4 reexpiry on time", {31'd0, irq}, 32'd1);
    disarm();

    // R10 period write while running
    wr(A_PER, 32'd4);
    wr(A_CTL, 32'h3);
    step(2);
    wr(A_PER, 32'd3);
    rd(A_PER, v); check("R10 new code stored", v, 32'd3);
    step(2 * TICK - 4);
    check("R10 old period kept, not early", {31'd0, irq}, 32'd0);
    step(1);
    check("R10 old period kept, expiry", {31'd0, irq}, 32'd1);
    wr(A_CTL, 32'h3);
    step(TICK - 1);
    check("R10 new code after clear, not early", {31'd0, irq}, 32'd0);
    step(1);
    check("R10 new code after clear, expiry", {31'd0, irq}, 32'd1);
    disarm();

    // R11 clear coincides with final tick
    wr(A_PER, 32'd3);
    wr(A_SEL, 32'd0);
    wr(A_CTL, 32'h3);
    step(7);
    wr(A_CTL, 32'h3);
    check("R11 expiry suppressed irq", {31'd0, irq}, 32'd0);
    check("R11 expiry suppressed rst", {31'd0, rst_req}, 32'd0);
    status_is("R7 ack dropped by clear", 1'b0);
    step(TICK - 1);
    check("R11 reload full, not early", {31'd0, irq}, 32'd0);
    step(1);
    check("R11 reload full, expiry", {31'd0, irq}, 32'd1);
    check("R11 reset after reload", {31'd0, rst_req}, 32'd1);
    disarm();

    // R4 random codes and selections
    for (int t = 0; t < 10; t++) begin
      int code, sel;
      code = int'($urandom % 16);
      sel  = int'($urandom % 4);
      arm_and_expect(code, sel, 32'h3);
      rd(A_PER, v); check("R3 random clamp", v, 32'(clamp_b(code)));
      disarm();
    end

    finish_run();
  end
endmodule